// File: doc/BRIEF.md
# Dual Reloading Down-Counter Timer

This block holds two identical periodic timers behind one small register bus. Each timer has a control word, an initial count and a current count, and the two share one status register of pending interrupt bits. Software arms a timer by writing a control word in which three gate bits are all set. That write copies the initial count into the current count, and the timer is then running.

While a timer runs, each cycle with `tick_en` high lowers its count by one. A tick that finds the count at zero reloads the initial count and sets that timer's pending bit, which drives its interrupt line. A timer armed with initial count N therefore raises an event every N+1 ticks. Software clears pending bits by writing ones to the status register. It may also force the current count at any time. The initial count can only be changed while the timer is stopped.

Top module: `tmr_pair`

## Requirements
- R1: After synchronous reset every register reads zero and both interrupt outputs are low.
- R2: Control bits 29, 30 and 31 are the interrupt gate, count gate and debug gate. Only a control write with all three bits set starts the timer, and it copies the initial count into the current count, which is readable the next cycle. A control write missing any of the three leaves the count unchanged.
- R3: While running, each cycle with `tick_en` high and no write to that timer lowers the count by exactly one. Cycles with `tick_en` low leave it unchanged.
- R4: A tick taken with the count at zero reloads the initial count and sets the timer's pending bit. Status bit 0 belongs to timer 0 and bit 1 to timer 1. An armed count of N gives one event per N+1 ticks.
- R5: A control write that clears any of the three gate bits stops the timer at once, and the count holds through later ticks.
- R6: A write to the initial count takes effect while the timer is stopped and is ignored while it runs.
- R7: A write to the current-count register sets the count directly. It takes priority over a tick in the same cycle.
- R8: Writing the status register clears each pending bit whose data bit is 1 and leaves bits written 0 unchanged. A reload in the same cycle as a clear leaves the bit set.
- R9: The two timers have separate registers, and neither one's activity changes the other's count or pending bit.
- R10: Word addresses: 0 and 1 are control for timers 0 and 1, 2 and 3 are initial count, 4 and 5 are current count, and 6 is status. Address 7 reads zero and ignores writes. Read data is combinational from the address.
- R11: `irq_o[i]` equals pending status bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| tick_en | input | 1 | Count enable pulse shared by both timers |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 2 | Per-timer interrupt request (pending bit) |

## Verification
A count register that is stuck or off by one shows up on the next readback of that count. It also moves the reload event by one tick, so `irq_o` rises a cycle early or late compared with the N+1 period. A wrong start decision, such as arming with a gate bit missing, shows as a count that was or was not loaded one cycle after the control write. Pending bits that clear on their own or clear the wrong bit show on `irq_o` in the cycle after the status write. Crosstalk between the timers shows up when the idle timer's count or pending bit is read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int N_TMR  = 2;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int IDX_W  = (N_TMR > 1) ? $clog2(N_TMR) : 1;

    // gate bits inside a control word
    localparam int GATE_IRQ = 29;
    localparam int GATE_CNT = 30;
    localparam int GATE_DBG = 31;

    typedef enum logic [2:0] {
        RK_CTRL,
        RK_INIT,
        RK_CNT,
        RK_STAT,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    function automatic logic gates_open(input logic [DATA_W-1:0] c);
        return c[GATE_IRQ] & c[GATE_CNT] & c[GATE_DBG];
    endfunction

    // registers are grouped by kind, one word per timer inside a group
    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        int       ai;
        ai     = int'(a);
        s.kind = RK_NONE;
        s.idx  = '0;
        if (ai < N_TMR) begin
            s.kind = RK_CTRL;
            s.idx  = IDX_W'(ai);
        end else if (ai < 2 * N_TMR) begin
            s.kind = RK_INIT;
            s.idx  = IDX_W'(ai - N_TMR);
        end else if (ai < 3 * N_TMR) begin
            s.kind = RK_CNT;
            s.idx  = IDX_W'(ai - 2 * N_TMR);
        end else if (ai == 3 * N_TMR) begin
            s.kind = RK_STAT;
        end
        return s;
    endfunction

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
    import tmr_pkg::*;
(
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_TMR-1:0]  ctrl_we,
    output logic [N_TMR-1:0]  init_we,
    output logic [N_TMR-1:0]  cnt_we,
    output logic              stat_we
);

    reg_sel_t sel;
    assign sel = decode(addr);

    always_comb begin
        ctrl_we = '0;
        init_we = '0;
        cnt_we  = '0;
        stat_we = 1'b0;
        if (we) begin
            case (sel.kind)
                RK_CTRL: ctrl_we[sel.idx] = 1'b1;
                RK_INIT: init_we[sel.idx] = 1'b1;
                RK_CNT:  cnt_we[sel.idx]  = 1'b1;
                RK_STAT: stat_we          = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              init_we,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  init_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              run_o,
    output logic              wrap_o
);

    logic any_wr;

    assign run_o  = gates_open(ctrl_q);
    assign any_wr = ctrl_we | cnt_we;
    // underflow event: a tick seen at zero with no competing write
    assign wrap_o = run_o & tick & ~any_wr & (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            init_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (ctrl_we)
                ctrl_q <= wdata;
            if (init_we && !run_o)
                init_q <= wdata[CNT_W-1:0];
            if (ctrl_we) begin
                if (gates_open(wdata))
                    cnt_q <= init_q;
            end else if (cnt_we) begin
                cnt_q <= wdata[CNT_W-1:0];
            end else if (run_o && tick) begin
                cnt_q <= (cnt_q == '0) ? init_q : cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tick_en,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_TMR-1:0]  irq_o
);

    logic [N_TMR-1:0]             ctrl_we, init_we, cnt_we;
    logic                         stat_we;
    logic [N_TMR-1:0][DATA_W-1:0] ctrl_q;
    logic [N_TMR-1:0][CNT_W-1:0]  init_q;
    logic [N_TMR-1:0][CNT_W-1:0]  cnt_q;
    logic [N_TMR-1:0]             run_vec;
    logic [N_TMR-1:0]             wrap_vec;
    logic [N_TMR-1:0]             pend_q;
    logic [N_TMR-1:0]             clr_mask;
    reg_sel_t                     rsel;

    tmr_regdec u_dec (
        .we      (bus_we),
        .addr    (bus_addr),
        .ctrl_we (ctrl_we),
        .init_we (init_we),
        .cnt_we  (cnt_we),
        .stat_we (stat_we)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_chan
        tmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ctrl_we (ctrl_we[g]),
            .init_we (init_we[g]),
            .cnt_we  (cnt_we[g]),
            .wdata   (bus_wdata),
            .tick    (tick_en),
            .ctrl_q  (ctrl_q[g]),
            .init_q  (init_q[g]),
            .cnt_q   (cnt_q[g]),
            .run_o   (run_vec[g]),
            .wrap_o  (wrap_vec[g])
        );
    end

    // write-one-to-clear, a same-cycle reload keeps the bit set
    assign clr_mask = stat_we ? bus_wdata[N_TMR-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_mask) | wrap_vec;
    end

    assign irq_o = pend_q;
    assign rsel  = decode(bus_addr);

    always_comb begin
        bus_rdata = '0;
        case (rsel.kind)
            RK_CTRL: bus_rdata = ctrl_q[rsel.idx];
            RK_INIT: bus_rdata = DATA_W'(init_q[rsel.idx]);
            RK_CNT:  bus_rdata = DATA_W'(cnt_q[rsel.idx]);
            RK_STAT: bus_rdata = DATA_W'(pend_q);
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_we,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        tick_en,
    input logic [N_TMR-1:0]            irq_o,
    input logic [N_TMR-1:0]            run_vec,
    input logic [N_TMR-1:0][CNT_W-1:0] cnt_q
);

    // R1: reset leaves no interrupt pending
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> irq_o == '0);

    for (genvar i = 0; i < N_TMR; i++) begin : g_chk
        // R2: a timer can only come alive through a write to its control word
        a_r2_start_by_write: assert property (@(posedge clk) disable iff (rst)
            $rose(run_vec[i]) |-> ($past(bus_we) && $past(bus_addr) == ADDR_W'(i)));

        // R3: one step down per tick
        a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
            (run_vec[i] && tick_en && !bus_we && cnt_q[i] != '0)
            |=> cnt_q[i] == $past(cnt_q[i]) - 1'b1);

        // R4: tick at zero raises the request next cycle
        a_r4_wrap_irq: assert property (@(posedge clk) disable iff (rst)
            (run_vec[i] && tick_en && !bus_we && cnt_q[i] == '0) |=> irq_o[i]);

        // R5: a stopped timer keeps its count
        a_r5_hold_stopped: assert property (@(posedge clk) disable iff (rst)
            (!run_vec[i] && !bus_we) |=> $stable(cnt_q[i]));

        // R8: a pending request stays until software writes
        a_r8_sticky_irq: assert property (@(posedge clk) disable iff (rst)
            (irq_o[i] && !bus_we) |=> irq_o[i]);
    end

endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .tick_en  (tick_en),
    .irq_o    (irq_o),
    .run_vec  (run_vec),
    .cnt_q    (cnt_q)
);

// File: tb/test_tmr_pair.sv
module test_tmr_pair;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;
    localparam logic [1:0] OP_IQ = 2'd3;
    localparam logic [31:0] GO = 32'hE000_0000;
    localparam int NV = 44;

    // {req, op, addr, data, expected}
    localparam logic [72:0] VEC [NV] = '{
        {4'd1,  OP_RD, 3'd0, 32'h0, 32'h0},          // R1 ctrl0
        {4'd1,  OP_RD, 3'd4, 32'h0, 32'h0},          // R1 count0
        {4'd1,  OP_RD, 3'd6, 32'h0, 32'h0},          // R1 status
        {4'd0,  OP_WR, 3'd2, 32'h3, 32'h0},
        {4'd6,  OP_RD, 3'd2, 32'h0, 32'h3},          // R6 stopped write taken
        {4'd0,  OP_WR, 3'd0, 32'h6000_0000, 32'h0},
        {4'd2,  OP_RD, 3'd4, 32'h0, 32'h0},          // R2 one gate missing
        {4'd0,  OP_WR, 3'd0, GO, 32'h0},
        {4'd2,  OP_RD, 3'd4, 32'h0, 32'h3},          // R2 loaded
        {4'd10, OP_RD, 3'd0, 32'h0, GO},             // R10 ctrl readback
        {4'd0,  OP_WR, 3'd2, 32'h9, 32'h0},
        {4'd6,  OP_RD, 3'd2, 32'h0, 32'h3},          // R6 ignored while running
        {4'd0,  OP_TK, 3'd0, 32'h0, 32'h0},
        {4'd3,  OP_RD, 3'd4, 32'h0, 32'h2},          // R3
        {4'd0,  OP_TK, 3'd0, 32'h0, 32'h0},
        {4'd0,  OP_TK, 3'd0, 32'h0, 32'h0},
        {4'd3,  OP_RD, 3'd4, 32'h0, 32'h0},          // R3
        {4'd11, OP_IQ, 3'd0, 32'h0, 32'h0},          // R11 nothing yet
        {4'd0,  OP_TK, 3'd0, 32'h0, 32'h0},
        {4'd4,  OP_RD, 3'd4, 32'h0, 32'h3},          // R4 reload after N+1 ticks
        {4'd4,  OP_IQ, 3'd0, 32'h0, 32'h1},          // R4
        {4'd11, OP_RD, 3'd6, 32'h0, 32'h1},          // R11 status matches irq
        {4'd0,  OP_WR, 3'd6, 32'h2, 32'h0},
        {4'd8,  OP_IQ, 3'd0, 32'h0, 32'h1},          // R8 zero bit keeps
        {4'd0,  OP_WR, 3'd6, 32'h1, 32'h0},
        {4'd8,  OP_IQ, 3'd0, 32'h0, 32'h0},          // R8 one bit clears
        {4'd0,  OP_WR, 3'd0, 32'hA000_0000, 32'h0},
        {4'd0,  OP_TK, 3'd0, 32'h0, 32'h0},
        {4'd5,  OP_RD, 3'd4, 32'h0, 32'h3},          // R5 held
        {4'd0,  OP_WR, 3'd4, 32'h7, 32'h0},
        {4'd7,  OP_RD, 3'd4, 32'h0, 32'h7},          // R7 forced
        {4'd0,  OP_WR, 3'd2, 32'h5, 32'h0},
        {4'd6,  OP_RD, 3'd2, 32'h0, 32'h5},          // R6
        {4'd0,  OP_WR, 3'd3, 32'h1, 32'h0},
        {4'd0,  OP_WR, 3'd1, GO, 32'h0},
        {4'd9,  OP_RD, 3'd5, 32'h0, 32'h1},          // R9 timer1 loaded
        {4'd9,  OP_RD, 3'd4, 32'h0, 32'h7},          // R9 timer0 untouched
        {4'd0,  OP_TK, 3'd0, 32'h0, 32'h0},
        {4'd0,  OP_TK, 3'd0, 32'h0, 32'h0},
        {4'd9,  OP_IQ, 3'd0, 32'h0, 32'h2},          // R9 only bit 1
        {4'd9,  OP_RD, 3'd4, 32'h0, 32'h7},          // R9
        {4'd0,  OP_WR, 3'd7, 32'hFFFF_FFFF, 32'h0},
        {4'd10, OP_RD, 3'd7, 32'h0, 32'h0},          // R10 hole reads zero
        {4'd10, OP_IQ, 3'd0, 32'h0, 32'h2}           // R10 hole write no effect
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        tick_en = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tmr_pair i_tmr_pair (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .tick_en   (tick_en),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NV; k++) begin
            logic [3:0]  rq;
            logic [1:0]  op;
            logic [2:0]  ad;
            logic [31:0] dt, ex;
            {rq, op, ad, dt, ex} = VEC[k];
            idle();
            case (op)
                OP_WR: begin bus_we = 1'b1; bus_addr = ad; bus_wdata = dt; end
                OP_TK: tick_en = 1'b1;
                OP_RD: begin
                    bus_addr = ad; #1;
                    check($sformatf("R%0d vec %0d", rq, k), bus_rdata, ex);
                end
                default: begin
                    #1;
                    check($sformatf("R%0d vec %0d", rq, k), {30'b0, irq_o}, ex);
                end
            endcase
        end
        // R7: count write beats a tick in the same cycle (timer1 holds 1)
        idle();
        bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h40; tick_en = 1'b1;
        idle();
        bus_addr = 3'd5; #1;
        check("R7 write over tick", bus_rdata, 32'h40);
        // R8: reload and clear in one cycle, the bit stays set
        idle();
        bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h2;
        idle();
        #1 check("R8 cleared first", {30'b0, irq_o}, 32'h0);
        bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h0;
        idle();
        bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h2; tick_en = 1'b1;
        idle();
        #1 check("R8 set wins", {30'b0, irq_o}, 32'h2);
        bus_addr = 3'd5; #1;
        check("R4 reload value", bus_rdata, 32'h1);
        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check("R1 irq after reset", {30'b0, irq_o}, 32'h0);
        bus_addr = 3'd1; #1;
        check("R1 ctrl1 after reset", bus_rdata, 32'h0);
        bus_addr = 3'd3; #1;
        check("R1 init1 after reset", bus_rdata, 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule